// File: doc/BRIEF.md
# Dual-Register Logic Cell with Selectable Clocking

This block models one output slice of a small programmable logic device. It holds two independent state bits. Each bit is driven from its own sum-of-products term, and each is set by configuration to store the term (D behaviour) or to flip when the term is 1 (T behaviour). Each bit takes its clock either from the shared dedicated clock pin or from its own product-term clock. Each bit has an asynchronous clear term of its own. A synchronous preset line is shared by both bits, and a test preload path can load either bit.

Both bits return to the logic array on feedback outputs, so either one can be kept internal. The bit chosen by a parameter drives the pad, with selectable polarity, under an output-enable term. The pad's input value returns to the array on its own path, whether or not the pad is being driven.

The cell runs on a fast system clock. The pin clock and the product-term clocks are treated as level signals, and a per-register edge-detect state machine finds their rising edges. The states are CK_ARM, CK_LOW and CK_HIGH, with these transitions:
- ARM→LOW: the source is seen low after reset.
- LOW→HIGH: the source is seen high. This is the firing edge.
- HIGH→LOW: the source falls.
- ARM and HIGH stay where they are while the source is high.

On each firing edge the register picks one update kind: UPD_PRELOAD, UPD_PRESET or UPD_DATA. On any other cycle it takes UPD_HOLD.

Top module: `mc_dual_macrocell`

## Requirements
- R1: While reset is low and just after it is released, both feedback bits are 0. pad_oe equals oe_term.
- R2: In D mode (ttype bit 0), a firing edge loads the bit's sum term into the register.
- R3: In T mode (ttype bit 1), a firing edge inverts the register when its sum term is 1, and leaves it unchanged when the sum term is 0.
- R4: With clock-select bit 0 a register fires only on rising edges of pin_clk. With clock-select bit 1 it fires only on rising edges of its own pt_clk bit. Edges on the unselected source have no effect.
- R5: A register fires only on a low-to-high change of its selected source. Holding the source high does not fire it again. A source that is already high when reset is released must be seen low before it can fire.
- R6: While a register's areset bit is 1, that register reads 0 at once and ignores edges. The other register is not affected.
- R7: When sync_preset is 1 at a firing edge, the register becomes 1 regardless of mode and sum term. A register that does not fire is left unchanged.
- R8: When preload_en is 1 at a firing edge, the register loads its preload_val bit. This takes priority over preset and over normal data.
- R9: Asynchronous clear takes priority over preload and preset.
- R10: pad_out equals the register at index OUT_IDX (default 0) XOR cfg_invert. pad_oe equals oe_term. The other register does not affect the pad.
- R11: pad_fb always equals pad_in, whatever the value of oe_term.
- R12: The two registers follow their own clock, mode, clear and data inputs independently under mixed random stimulus.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Power-up reset, active low, asynchronous |
| pin_clk | input | 1 | Dedicated clock pin level |
| pt_clk | input | 2 | Per-register product-term clock levels |
| cfg_ptclk | input | 2 | Per-register clock select (1 = product-term clock) |
| cfg_ttype | input | 2 | Per-register mode (1 = T, 0 = D) |
| cfg_invert | input | 1 | Pad polarity (1 = inverted) |
| sum_term | input | 2 | Per-register sum-of-products data |
| areset_term | input | 2 | Per-register asynchronous clear |
| sync_preset | input | 1 | Shared synchronous preset |
| preload_en | input | 1 | Test preload enable |
| preload_val | input | 2 | Test preload values |
| oe_term | input | 1 | Output-enable product term |
| pad_in | input | 1 | Value seen at the pad |
| fb_q | output | 2 | Register feedback to the array |
| pad_out | output | 1 | Data driven toward the pad |
| pad_oe | output | 1 | Pad tri-state enable |
| pad_fb | output | 1 | Pad input path to the array |

## Verification
Register results are due one system clock after the selected source is first driven high. The bench changes inputs on the falling clock edge and reads fb_q at the following falling edge, after exactly one rising edge. The asynchronous clear, the pad data, the enable and the input path respond without a clock, so the bench reads them 1 ns after it changes the input. In the random phase a bench model advances once per rising edge and applies clears as soon as they are driven. Every falling-edge sample is compared with that model.

// File: rtl/mc_pkg.sv
package mc_pkg;
    typedef enum logic [1:0] {
        CK_ARM  = 2'd0,
        CK_LOW  = 2'd1,
        CK_HIGH = 2'd2
    } ck_state_t;

    typedef enum logic [1:0] {
        UPD_HOLD    = 2'd0,
        UPD_PRELOAD = 2'd1,
        UPD_PRESET  = 2'd2,
        UPD_DATA    = 2'd3
    } upd_t;
endpackage

// File: rtl/mc_clk_sel.sv
module mc_clk_sel
    import mc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic pin_clk,
    input  logic pt_clk,
    input  logic sel_pt,
    output logic fire
);
    ck_state_t state, state_nxt;
    logic      lvl;

    assign lvl = sel_pt ? pt_clk : pin_clk;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= CK_ARM;
        else        state <= state_nxt;
    end

    always_comb begin
        state_nxt = state;
        unique case (state)
            CK_ARM:  state_nxt = lvl ? CK_ARM  : CK_LOW;
            CK_LOW:  state_nxt = lvl ? CK_HIGH : CK_LOW;
            CK_HIGH: state_nxt = lvl ? CK_HIGH : CK_LOW;
            default: state_nxt = CK_ARM;
        endcase
    end

    always_comb begin
        fire = 1'b0;
        unique case (state)
            CK_LOW:  fire = lvl;
            default: fire = 1'b0;
        endcase
    end

    // R5: a held-high source never produces two firings in a row
    a_r5_single_fire: assert property (@(posedge clk) disable iff (!rst_n)
        fire |=> !fire);
    // R5: no firing while still armed from reset
    a_r5_arm_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (state == CK_ARM) |-> !fire);
endmodule

// File: rtl/mc_reg_cell.sv
module mc_reg_cell
    import mc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic ares,
    input  logic fire,
    input  logic ttype,
    input  logic sum,
    input  logic preset,
    input  logic preload_en,
    input  logic preload_val,
    output logic q
);
    upd_t upd;
    logic q_nxt;
    logic clr_n;

    assign clr_n = rst_n & ~ares;

    always_comb begin
        if (!fire)           upd = UPD_HOLD;
        else if (preload_en) upd = UPD_PRELOAD;
        else if (preset)     upd = UPD_PRESET;
        else                 upd = UPD_DATA;
    end

    always_comb begin
        q_nxt = q;
        unique case (upd)
            UPD_HOLD:    q_nxt = q;
            UPD_PRELOAD: q_nxt = preload_val;
            UPD_PRESET:  q_nxt = 1'b1;
            UPD_DATA:    q_nxt = ttype ? (q ^ sum) : sum;
            default:     q_nxt = q;
        endcase
    end

    always_ff @(posedge clk or negedge clr_n) begin
        if (!clr_n) q <= 1'b0;
        else        q <= q_nxt;
    end

    a_r6_clear_held: assert property (@(posedge clk) disable iff (!rst_n)
        ares |-> !q);
    a_r7_preset_sets: assert property (@(posedge clk) disable iff (!rst_n || ares)
        fire && preset && !preload_en |=> q);
    a_r8_preload_loads: assert property (@(posedge clk) disable iff (!rst_n || ares)
        fire && preload_en |=> q == $past(preload_val));
    a_r3_toggle: assert property (@(posedge clk) disable iff (!rst_n || ares)
        fire && ttype && !preset && !preload_en |=> q == ($past(q) ^ $past(sum)));
    a_r2_dload: assert property (@(posedge clk) disable iff (!rst_n || ares)
        fire && !ttype && !preset && !preload_en |=> q == $past(sum));
    a_r5_hold: assert property (@(posedge clk) disable iff (!rst_n || ares)
        !fire |=> $stable(q));
endmodule

// File: rtl/mc_out_drv.sv
module mc_out_drv (
    input  logic q_sel,
    input  logic invert,
    input  logic oe_term,
    input  logic pad_in,
    output logic pad_out,
    output logic pad_oe,
    output logic pad_fb
);
    assign pad_out = q_sel ^ invert;
    assign pad_oe  = oe_term;
    assign pad_fb  = pad_in;

    a_r11_input_path: assert final (pad_fb === pad_in);
endmodule

// File: rtl/mc_dual_macrocell.sv
module mc_dual_macrocell #(
    parameter int NREG    = 2,
    parameter int OUT_IDX = 0
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            pin_clk,
    input  logic [NREG-1:0] pt_clk,
    input  logic [NREG-1:0] cfg_ptclk,
    input  logic [NREG-1:0] cfg_ttype,
    input  logic            cfg_invert,
    input  logic [NREG-1:0] sum_term,
    input  logic [NREG-1:0] areset_term,
    input  logic            sync_preset,
    input  logic            preload_en,
    input  logic [NREG-1:0] preload_val,
    input  logic            oe_term,
    input  logic            pad_in,
    output logic [NREG-1:0] fb_q,
    output logic            pad_out,
    output logic            pad_oe,
    output logic            pad_fb
);
    logic [NREG-1:0] fire;

    for (genvar g = 0; g < NREG; g++) begin : g_reg
        mc_clk_sel u_ck (
            .clk     (clk),
            .rst_n   (rst_n),
            .pin_clk (pin_clk),
            .pt_clk  (pt_clk[g]),
            .sel_pt  (cfg_ptclk[g]),
            .fire    (fire[g])
        );
        mc_reg_cell u_rg (
            .clk         (clk),
            .rst_n       (rst_n),
            .ares        (areset_term[g]),
            .fire        (fire[g]),
            .ttype       (cfg_ttype[g]),
            .sum         (sum_term[g]),
            .preset      (sync_preset),
            .preload_en  (preload_en),
            .preload_val (preload_val[g]),
            .q           (fb_q[g])
        );
    end

    mc_out_drv u_out (
        .q_sel   (fb_q[OUT_IDX]),
        .invert  (cfg_invert),
        .oe_term (oe_term),
        .pad_in  (pad_in),
        .pad_out (pad_out),
        .pad_oe  (pad_oe),
        .pad_fb  (pad_fb)
    );

    // R1: registers are clear during power-up reset
    a_r1_reset_clear: assert property (@(posedge clk) !rst_n |-> fb_q == '0);
endmodule

// File: tb/sim_mc_dual_macrocell.sv
`timescale 1ns/1ps
module sim_mc_dual_macrocell;
    logic clk = 0, rst_n = 0, pin_clk = 0, cfg_invert = 0, sync_preset = 0;
    logic preload_en = 0, oe_term = 0, pad_in = 0;
    logic [1:0] pt_clk = 0, cfg_ptclk = 0, cfg_ttype = 0, sum_term = 0;
    logic [1:0] areset_term = 0, preload_val = 0;
    logic [1:0] fb_q;
    logic pad_out, pad_oe, pad_fb;
    int n_chk = 0, n_bad = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    mc_dual_macrocell u0 (.*);

    task automatic check(string req, logic [1:0] act, logic [1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%b expected=%b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic tick;
        @(posedge clk); @(negedge clk);
    endtask

    task automatic pulse(input logic pin, input logic [1:0] pt);
        pin_clk = pin; pt_clk = pt; tick();
        pin_clk = 0;   pt_clk = 0;  tick();
    endtask

    task automatic do_reset(input logic pin_hi);
        @(negedge clk); rst_n = 0; pin_clk = pin_hi; pt_clk = 0;
        tick(); tick(); rst_n = 1;
    endtask

    // bench model: 0 = armed, 1 = low, 2 = high
    int         m_st[2];
    logic [1:0] m_q;

    function automatic void model_step();
        for (int i = 0; i < 2; i++) begin
            logic lvl, fire;
            lvl  = cfg_ptclk[i] ? pt_clk[i] : pin_clk;
            fire = (m_st[i] == 1) && lvl;
            m_st[i] = lvl ? ((m_st[i] == 0) ? 0 : 2) : 1;
            if (areset_term[i])   m_q[i] = 0;
            else if (fire) begin
                if (preload_en)       m_q[i] = preload_val[i];
                else if (sync_preset) m_q[i] = 1;
                else if (cfg_ttype[i]) m_q[i] = m_q[i] ^ sum_term[i];
                else                   m_q[i] = sum_term[i];
            end
        end
    endfunction

    task automatic summary;
        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    endtask

    initial begin
        #1_000_000;
        n_chk++; n_bad++;
        $display("FAIL watchdog expired");
        summary();
    end

    initial begin
        void'($urandom(32'h5EED_0017));
        @(negedge clk); oe_term = 1;
        #1; check("R1 reset", fb_q, 2'b00);
        check("R1 oe", {1'b0, pad_oe}, 2'b01);
        rst_n = 1; tick();
        check("R1 after release", fb_q, 2'b00);

        sum_term = 2'b01; pulse(1, 0); check("R2 load 01", fb_q, 2'b01);
        sum_term = 2'b10; pulse(1, 0); check("R2 load 10", fb_q, 2'b10);

        sum_term = 2'b01; pin_clk = 1; tick(); check("R5 first edge", fb_q, 2'b01);
        sum_term = 2'b10; tick(); tick(); check("R5 held high", fb_q, 2'b01);
        pin_clk = 0; tick();

        cfg_ttype = 2'b11; sum_term = 2'b11; pulse(1, 0); check("R3 toggle", fb_q, 2'b10);
        sum_term = 2'b00; pulse(1, 0); check("R3 hold on 0", fb_q, 2'b10);
        sum_term = 2'b10; pulse(1, 0); check("R3 toggle back", fb_q, 2'b00);

        cfg_ttype = 2'b00; cfg_ptclk = 2'b10; sum_term = 2'b11;
        pulse(0, 2'b10); check("R4 pt clock only reg1", fb_q, 2'b10);
        sum_term = 2'b01; pulse(1, 0); check("R4 pin clock only reg0", fb_q, 2'b11);
        sum_term = 2'b00; pulse(0, 2'b01); check("R4 unselected source", fb_q, 2'b11);

        areset_term = 2'b11; #1; check("R6 immediate clear", fb_q, 2'b00);
        @(negedge clk); areset_term = 0; tick();
        sync_preset = 1; sum_term = 2'b00; pulse(1, 0);
        check("R7 preset on firing reg only", fb_q, 2'b01);
        sync_preset = 0;

        areset_term = 2'b01; #1; check("R6 clear one", fb_q, 2'b00);
        @(negedge clk); sum_term = 2'b11; pulse(1, 0);
        check("R6 edge ignored while clear", fb_q, 2'b00);
        areset_term = 0; tick(); check("R6 stays clear", fb_q, 2'b00);

        preload_en = 1; preload_val = 2'b10; sync_preset = 1; sum_term = 2'b01;
        pulse(1, 2'b10); check("R8 preload beats preset", fb_q, 2'b10);
        sync_preset = 0;
        areset_term = 2'b10; preload_val = 2'b11; pulse(1, 2'b10);
        check("R9 clear beats preload", fb_q, 2'b01);
        areset_term = 0; preload_en = 0; tick();

        cfg_invert = 0; #1; check("R10 true polarity", {1'b0, pad_out}, 2'b01);
        cfg_invert = 1; #1; check("R10 inverted", {1'b0, pad_out}, 2'b00);
        oe_term = 0; #1; check("R10 oe low", {1'b0, pad_oe}, 2'b00);
        @(negedge clk); cfg_ttype = 2'b10; sum_term = 2'b10; pulse(0, 2'b10);
        check("R10 reg1 toggled", fb_q, 2'b11);
        check("R10 pad unaffected by reg1", {1'b0, pad_out}, 2'b00);

        for (int k = 0; k < 4; k++) begin
            oe_term = k[0]; pad_in = k[1]; #1;
            check("R11 input path", {1'b0, pad_fb}, {1'b0, k[1]});
        end

        cfg_ptclk = 0; cfg_ttype = 0; sum_term = 2'b11;
        do_reset(1); tick(); tick();
        check("R5 armed after reset", fb_q, 2'b00);
        pin_clk = 0; tick(); pin_clk = 1; tick();
        check("R5 fires after low", fb_q, 2'b11);

        do_reset(0);
        m_st[0] = 0; m_st[1] = 0; m_q = 0;
        for (int c = 0; c < 600; c++) begin
            pin_clk     = 1'($urandom % 2);
            pt_clk      = 2'($urandom % 4);
            cfg_ptclk   = ($urandom % 8 == 0) ? 2'($urandom % 4) : cfg_ptclk;
            cfg_ttype   = ($urandom % 8 == 0) ? 2'($urandom % 4) : cfg_ttype;
            cfg_invert  = 1'($urandom % 2);
            sum_term    = 2'($urandom % 4);
            areset_term = {($urandom % 16 == 0), ($urandom % 16 == 0)};
            sync_preset = ($urandom % 4 == 0);
            preload_en  = ($urandom % 8 == 0);
            preload_val = 2'($urandom % 4);
            for (int i = 0; i < 2; i++) if (areset_term[i]) m_q[i] = 0;
            @(posedge clk); model_step();
            @(negedge clk);
            check("R12 random regs", fb_q, m_q);
            check("R10 random pad", {1'b0, pad_out}, {1'b0, m_q[0] ^ cfg_invert});
        end
        summary();
    end
endmodule